// File: doc/BRIEF.md
# Automatic RTS/CTS Hardware Handshake Controller

This block runs automatic hardware handshaking for one serial channel. On the receive side it watches the receive FIFO fill count. It raises the active-low request-to-send output once the count reaches a programmable halt threshold. It lowers that output again only after the count has drained to a separate, lower resume threshold. Both thresholds are 4-bit codes scaled by four, so they cover 0 to 60 bytes. The gap between the two thresholds gives hysteresis.

On the transmit side the block takes the active-low clear-to-send input through a two-flop synchronizer. It then grants or withholds permission for the transmitter to start its next character. A character that has already started always runs to its stop bit. Permission is withdrawn only at the character boundary, which the transmitter marks with a done pulse. Every change of the synchronized clear-to-send input sets a sticky delta flag. A flow-control interrupt flag records handshake events. Both flags clear on a modem-status read strobe.

Two finite-state machines do the work. The receive machine has two states. RTS_FLOWING drives the request output low, and RTS_HOLDING drives it high. HALT_REACHED moves it from FLOWING to HOLDING. RESUME_REACHED or AUTO_OFF moves it back. The transmit machine has four states: TX_OPEN grants a start; TX_SENDING has a character in flight while sending is allowed; TX_DRAINING has a character in flight while clear-to-send is withdrawn; TX_PAUSED has halted at a boundary. Its transitions are:

- START (OPEN to SENDING)
- START_BLOCKED (OPEN to DRAINING)
- BLOCK (OPEN to PAUSED)
- DONE (SENDING to OPEN)
- DONE_BLOCKED (SENDING to PAUSED)
- WITHDRAW (SENDING to DRAINING)
- RESTORE (DRAINING to SENDING)
- DRAINED (DRAINING to PAUSED)
- RELEASE (PAUSED to OPEN)

Top module: `flow_hs_ctrl`

## Requirements
- R1: While auto RTS is enabled and the receive machine is in RTS_FLOWING, `rts_n` goes high one clock after `rx_level` is at or above `halt_code`×4.
- R2: While the receive machine is in RTS_HOLDING, `rts_n` stays high while `rx_level` is above `resume_code`×4. It goes low one clock after `rx_level` is at or below `resume_code`×4.
- R3: When auto RTS is disabled, `rts_n` is low one clock later whatever the fill level, and that change does not raise `flow_irq`.
- R4: `cts_n_in` passes through two synchronizing flops. A change becomes visible on `tx_enable` after the third rising clock edge, and not after the second.
- R5: With auto CTS enabled, a deassertion of clear-to-send (`cts_n_in` high) during a character keeps `tx_enable` low through that character. After `char_done`, the transmitter stays halted (`tx_enable` low).
- R6: With auto CTS enabled, `tx_enable` rises only when synchronized clear-to-send is asserted (low). If clear-to-send returns during a character, `tx_enable` is high one clock after that character's `char_done`.
- R7: With auto CTS disabled, `cts_n_in` never holds `tx_enable` low once no character is in flight.
- R8: `tx_enable` is low one clock after a `char_start` that it permitted, and it stays low until the character's `char_done`.
- R9: Every change of synchronized clear-to-send sets `cts_delta`, one edge after the synchronizer output changes. `msr_read` clears it. If a set and a clear fall in the same clock, the set wins.
- R10: `flow_irq` is set by a synchronized clear-to-send change while auto CTS is enabled, or by an `rts_n` change while auto RTS is enabled. It clears only on `msr_read`.
- R11: After reset, `rts_n` is low, `cts_delta` and `flow_irq` are low, and the synchronizer holds clear-to-send deasserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| auto_rts_en | input | 1 | Enables threshold-driven `rts_n` |
| auto_cts_en | input | 1 | Enables clear-to-send gating of the transmitter |
| halt_code | input | 4 | Halt threshold code (level = code×4) |
| resume_code | input | 4 | Resume threshold code (level = code×4) |
| rx_level | input | 7 | Receive FIFO fill count |
| cts_n_in | input | 1 | Asynchronous active-low clear-to-send |
| char_start | input | 1 | Pulse: transmitter began a character |
| char_done | input | 1 | Pulse: stop bit of current character finished |
| msr_read | input | 1 | Pulse: modem status read, clears flags |
| rts_n | output | 1 | Active-low request-to-send |
| tx_enable | output | 1 | Permission to start the next character |
| cts_state | output | 1 | Synchronized clear-to-send, active high |
| cts_delta | output | 1 | Sticky clear-to-send change flag |
| flow_irq | output | 1 | Sticky flow-control interrupt flag |

## Verification
The bench checks both edges of the hysteresis window: one below the halt level, exactly the halt level, a level between the two thresholds, and exactly the resume level. An inclusive or exclusive comparison in the wrong place would flip `rts_n` one byte early or late. It withdraws clear-to-send in the middle of a character and restores it in the middle of a character. A design that gates immediately would drop a character half-sent. A design that forgets the restore would halt wrongly after `char_done`. The bench samples `tx_enable` after the second and after the third edge following a clear-to-send change, to catch a missing or extra synchronizer stage. It also lands `msr_read` on the very clock that sets `cts_delta`, which exposes a clear that takes priority over the set.

// File: rtl/fc_pkg.sv
package fc_pkg;

    // Receive-side handshake state: drives rts_n
    typedef enum logic {
        RTS_FLOWING = 1'b0,
        RTS_HOLDING = 1'b1
    } rts_state_e;

    // Transmit-side gating state
    typedef enum logic [1:0] {
        TX_OPEN     = 2'd0,
        TX_SENDING  = 2'd1,
        TX_DRAINING = 2'd2,
        TX_PAUSED   = 2'd3
    } tx_state_e;

endpackage

// File: rtl/fc_sync.sv
module fc_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= RST_VAL;
                else        chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= {STAGES{RST_VAL}};
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/fc_rts_fsm.sv
module fc_rts_fsm
    import fc_pkg::*;
#(
    parameter int LVL_W      = 7,
    parameter int CODE_W     = 4,
    parameter int STEP_SHIFT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [CODE_W-1:0] halt_code,
    input  logic [CODE_W-1:0] resume_code,
    input  logic [LVL_W-1:0]  rx_level,
    output logic              rts_n
);

    localparam int THR_W = CODE_W + STEP_SHIFT;

    logic [LVL_W-1:0] halt_thr;
    logic [LVL_W-1:0] resume_thr;
    logic             halt_hit;
    logic             resume_hit;

    rts_state_e state_q;
    rts_state_e state_d;

    assign halt_thr   = LVL_W'({halt_code,   {STEP_SHIFT{1'b0}}});
    assign resume_thr = LVL_W'({resume_code, {STEP_SHIFT{1'b0}}});
    assign halt_hit   = (rx_level >= halt_thr);
    assign resume_hit = (rx_level <= resume_thr);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RTS_FLOWING: begin
                if (enable && halt_hit) state_d = RTS_HOLDING;    // HALT_REACHED
            end
            RTS_HOLDING: begin
                if (!enable)         state_d = RTS_FLOWING;       // AUTO_OFF
                else if (resume_hit) state_d = RTS_FLOWING;       // RESUME_REACHED
            end
            default: state_d = RTS_FLOWING;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RTS_FLOWING;
        else        state_q <= state_d;
    end

    // Output decode
    always_comb begin
        unique case (state_q)
            RTS_FLOWING: rts_n = 1'b0;
            RTS_HOLDING: rts_n = 1'b1;
            default:     rts_n = 1'b0;
        endcase
    end

    logic unused_thr_w;
    assign unused_thr_w = (THR_W > LVL_W);

endmodule

// File: rtl/fc_tx_gate_fsm.sv
module fc_tx_gate_fsm
    import fc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic gate_en,
    input  logic cts_n_sync,
    input  logic char_start,
    input  logic char_done,
    output logic tx_enable
);

    logic      stop_req;
    tx_state_e state_q;
    tx_state_e state_d;

    assign stop_req = gate_en & cts_n_sync;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_OPEN: begin
                if (char_start) state_d = stop_req ? TX_DRAINING : TX_SENDING; // START / START_BLOCKED
                else if (stop_req) state_d = TX_PAUSED;                        // BLOCK
            end
            TX_SENDING: begin
                if (char_done) state_d = stop_req ? TX_PAUSED : TX_OPEN;       // DONE_BLOCKED / DONE
                else if (stop_req) state_d = TX_DRAINING;                      // WITHDRAW
            end
            TX_DRAINING: begin
                if (char_done) begin
                    state_d = stop_req ? TX_PAUSED : TX_OPEN;                  // DRAINED
                end else if (!stop_req) begin
                    state_d = TX_SENDING;                                      // RESTORE
                end
            end
            TX_PAUSED: begin
                if (!stop_req) state_d = TX_OPEN;                              // RELEASE
            end
            default: state_d = TX_OPEN;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_OPEN;
        else        state_q <= state_d;
    end

    // Output decode
    always_comb begin
        unique case (state_q)
            TX_OPEN:     tx_enable = 1'b1;
            TX_SENDING:  tx_enable = 1'b0;
            TX_DRAINING: tx_enable = 1'b0;
            TX_PAUSED:   tx_enable = 1'b0;
            default:     tx_enable = 1'b0;
        endcase
    end

endmodule

// File: rtl/fc_status.sv
module fc_status (
    input  logic clk,
    input  logic rst_n,
    input  logic cts_n_sync,
    input  logic rts_n,
    input  logic auto_cts_en,
    input  logic auto_rts_en,
    input  logic msr_read,
    output logic cts_delta,
    output logic flow_irq
);

    logic cts_prev;
    logic rts_prev;
    logic cts_chg;
    logic rts_chg;
    logic irq_set;

    assign cts_chg = cts_n_sync ^ cts_prev;
    assign rts_chg = rts_n ^ rts_prev;
    assign irq_set = (cts_chg & auto_cts_en) | (rts_chg & auto_rts_en);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cts_prev  <= 1'b1;
            rts_prev  <= 1'b0;
            cts_delta <= 1'b0;
            flow_irq  <= 1'b0;
        end else begin
            cts_prev  <= cts_n_sync;
            rts_prev  <= rts_n;
            cts_delta <= cts_chg | (cts_delta & ~msr_read);
            flow_irq  <= irq_set | (flow_irq & ~msr_read);
        end
    end

endmodule

// File: rtl/flow_hs_ctrl.sv
module flow_hs_ctrl #(
    parameter int LVL_W       = 7,
    parameter int CODE_W      = 4,
    parameter int STEP_SHIFT  = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              auto_rts_en,
    input  logic              auto_cts_en,
    input  logic [CODE_W-1:0] halt_code,
    input  logic [CODE_W-1:0] resume_code,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic              cts_n_in,
    input  logic              char_start,
    input  logic              char_done,
    input  logic              msr_read,
    output logic              rts_n,
    output logic              tx_enable,
    output logic              cts_state,
    output logic              cts_delta,
    output logic              flow_irq
);

    logic cts_n_sync;

    fc_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) u_cts_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (cts_n_in),
        .q     (cts_n_sync)
    );

    fc_rts_fsm #(
        .LVL_W      (LVL_W),
        .CODE_W     (CODE_W),
        .STEP_SHIFT (STEP_SHIFT)
    ) u_rts (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (auto_rts_en),
        .halt_code   (halt_code),
        .resume_code (resume_code),
        .rx_level    (rx_level),
        .rts_n       (rts_n)
    );

    fc_tx_gate_fsm u_txg (
        .clk        (clk),
        .rst_n      (rst_n),
        .gate_en    (auto_cts_en),
        .cts_n_sync (cts_n_sync),
        .char_start (char_start),
        .char_done  (char_done),
        .tx_enable  (tx_enable)
    );

    fc_status u_stat (
        .clk         (clk),
        .rst_n       (rst_n),
        .cts_n_sync  (cts_n_sync),
        .rts_n       (rts_n),
        .auto_cts_en (auto_cts_en),
        .auto_rts_en (auto_rts_en),
        .msr_read    (msr_read),
        .cts_delta   (cts_delta),
        .flow_irq    (flow_irq)
    );

    assign cts_state = ~cts_n_sync;

endmodule

// File: rtl/flow_hs_ctrl_chk.sv
module flow_hs_ctrl_chk #(
    parameter int LVL_W      = 7,
    parameter int CODE_W     = 4,
    parameter int STEP_SHIFT = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              auto_rts_en,
    input logic              auto_cts_en,
    input logic [CODE_W-1:0] halt_code,
    input logic [CODE_W-1:0] resume_code,
    input logic [LVL_W-1:0]  rx_level,
    input logic              char_start,
    input logic              char_done,
    input logic              msr_read,
    input logic              rts_n,
    input logic              tx_enable,
    input logic              cts_delta,
    input logic              flow_irq,
    input logic              cts_n_sync
);

    logic [LVL_W-1:0] halt_lvl;
    logic [LVL_W-1:0] resume_lvl;

    assign halt_lvl   = LVL_W'(halt_code)   << STEP_SHIFT;
    assign resume_lvl = LVL_W'(resume_code) << STEP_SHIFT;

    assert_rts_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rts_n) |-> ($past(auto_rts_en) && ($past(rx_level) >= $past(halt_lvl))));

    assert_rts_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rts_n) |-> (!$past(auto_rts_en) || ($past(rx_level) <= $past(resume_lvl))));

    assert_rts_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_rts_en |=> !rts_n);

    assert_tx_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_enable) |-> (!$past(auto_cts_en) || !$past(cts_n_sync)));

    assert_cts_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (char_done && !char_start && !auto_cts_en) |=> tx_enable);

    assert_busy_after_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (char_start && tx_enable) |=> !tx_enable);

    assert_delta_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cts_delta) |-> $past(msr_read));

    assert_irq_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flow_irq) |-> $past(msr_read));

endmodule

bind flow_hs_ctrl flow_hs_ctrl_chk #(
    .LVL_W      (LVL_W),
    .CODE_W     (CODE_W),
    .STEP_SHIFT (STEP_SHIFT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .auto_rts_en (auto_rts_en),
    .auto_cts_en (auto_cts_en),
    .halt_code   (halt_code),
    .resume_code (resume_code),
    .rx_level    (rx_level),
    .char_start  (char_start),
    .char_done   (char_done),
    .msr_read    (msr_read),
    .rts_n       (rts_n),
    .tx_enable   (tx_enable),
    .cts_delta   (cts_delta),
    .flow_irq    (flow_irq),
    .cts_n_sync  (cts_n_sync)
);

// File: tb/flow_hs_ctrl_tb.sv
`timescale 1ns/1ps
module flow_hs_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       auto_rts_en, auto_cts_en;
    logic [3:0] halt_code, resume_code;
    logic [6:0] rx_level;
    logic       cts_n_in, char_start, char_done, msr_read;
    logic       rts_n, tx_enable, cts_state, cts_delta, flow_irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    flow_hs_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .auto_rts_en(auto_rts_en), .auto_cts_en(auto_cts_en),
        .halt_code(halt_code), .resume_code(resume_code),
        .rx_level(rx_level), .cts_n_in(cts_n_in),
        .char_start(char_start), .char_done(char_done), .msr_read(msr_read),
        .rts_n(rts_n), .tx_enable(tx_enable), .cts_state(cts_state),
        .cts_delta(cts_delta), .flow_irq(flow_irq)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    // Advance n rising edges, then stop on the following falling edge
    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_flags();
        msr_read = 1'b1; step(1); msr_read = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; auto_rts_en = 0; auto_cts_en = 0;
        halt_code = 0; resume_code = 0; rx_level = 0;
        cts_n_in = 1'b1; char_start = 0; char_done = 0; msr_read = 0;
        step(3);
        rst_n = 1'b1;
        step(1);
        check("R11 rts_n after reset", rts_n, 1'b0);
        check("R11 cts_delta after reset", cts_delta, 1'b0);
        check("R11 flow_irq after reset", flow_irq, 1'b0);
        check("R11 cts_state after reset", cts_state, 1'b0);
    endtask

    task automatic t_rts_window();
        auto_rts_en = 1; halt_code = 4'd8; resume_code = 4'd4;
        rx_level = 7'd31; step(1);
        check("R1 level 31 below halt 32", rts_n, 1'b0);
        rx_level = 7'd32; step(1);
        check("R1 level 32 at halt", rts_n, 1'b1);
        step(1);
        check("R10 irq on rts change", flow_irq, 1'b1);
        clear_flags();
        check("R10 irq cleared by read", flow_irq, 1'b0);
        rx_level = 7'd20; step(1);
        check("R2 level 20 inside window holds", rts_n, 1'b1);
        rx_level = 7'd17; step(1);
        check("R2 level 17 above resume holds", rts_n, 1'b1);
        rx_level = 7'd16; step(1);
        check("R2 level 16 at resume", rts_n, 1'b0);
        rx_level = 7'd20; step(1);
        check("R2 level 20 after resume stays low", rts_n, 1'b0);
        halt_code = 4'd15; rx_level = 7'd59; step(1);
        check("R1 level 59 below halt 60", rts_n, 1'b0);
        rx_level = 7'd60; step(1);
        check("R1 level 60 at max halt", rts_n, 1'b1);
        step(1);
        clear_flags();
        auto_rts_en = 0; step(1);
        check("R3 auto RTS off releases rts_n", rts_n, 1'b0);
        step(1);
        check("R3 no irq from disabled RTS", flow_irq, 1'b0);
        rx_level = 7'd0;
    endtask

    task automatic t_cts_auto_off();
        check("R7 tx_enable with CTS high, auto off", tx_enable, 1'b1);
        char_start = 1; step(1); char_start = 0;
        check("R8 busy after start", tx_enable, 1'b0);
        step(2);
        check("R8 still busy mid character", tx_enable, 1'b0);
        char_done = 1; step(1); char_done = 0;
        check("R7 open after done, CTS ignored", tx_enable, 1'b1);
    endtask

    task automatic t_cts_enable();
        auto_cts_en = 1; step(1);
        check("R5 CTS high blocks when auto on", tx_enable, 1'b0);
        cts_n_in = 1'b0; step(2);
        check("R4 two edges not yet released", tx_enable, 1'b0);
        step(1);
        check("R4 third edge released", tx_enable, 1'b1);
        check("R9 delta on CTS change", cts_delta, 1'b1);
        check("R10 irq on CTS change", flow_irq, 1'b1);
        clear_flags();
        check("R9 delta cleared by read", cts_delta, 1'b0);
        check("R10 irq cleared by read", flow_irq, 1'b0);
    endtask

    task automatic t_mid_char_halt();
        char_start = 1; step(1); char_start = 0;
        cts_n_in = 1'b1; step(3);
        check("R5 draining keeps tx_enable low", tx_enable, 1'b0);
        char_done = 1; step(1); char_done = 0;
        check("R5 halted at boundary", tx_enable, 1'b0);
        step(5);
        check("R5 stays halted", tx_enable, 1'b0);
        cts_n_in = 1'b0; step(3);
        check("R6 resume after CTS low", tx_enable, 1'b1);
        clear_flags();
    endtask

    task automatic t_mid_char_restore();
        char_start = 1; step(1); char_start = 0;
        cts_n_in = 1'b1; step(3);
        cts_n_in = 1'b0; step(3);
        check("R6 restored char still busy", tx_enable, 1'b0);
        char_done = 1; step(1); char_done = 0;
        check("R6 open right after done", tx_enable, 1'b1);
        clear_flags();
    endtask

    task automatic t_sync_latency();
        cts_n_in = 1'b1; step(2);
        check("R4 withdraw not seen after two edges", tx_enable, 1'b1);
        step(1);
        check("R4 withdraw seen after third edge", tx_enable, 1'b0);
        cts_n_in = 1'b0; step(3);
        clear_flags();
    endtask

    task automatic t_delta_priority();
        cts_n_in = 1'b1; step(2);
        msr_read = 1'b1; step(1); msr_read = 1'b0;
        check("R9 set wins over read", cts_delta, 1'b1);
        clear_flags();
        check("R9 cleared afterwards", cts_delta, 1'b0);
        auto_cts_en = 0;
        cts_n_in = 1'b0; step(3);
        check("R9 delta with auto CTS off", cts_delta, 1'b1);
        check("R10 no irq with auto CTS off", flow_irq, 1'b0);
        check("R7 tx_enable with auto off", tx_enable, 1'b1);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    endtask

    initial begin
        t_reset();
        t_rts_window();
        t_cts_auto_off();
        t_cts_enable();
        t_mid_char_halt();
        t_mid_char_restore();
        t_sync_latency();
        t_delta_priority();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

endmodule